// File: doc/BRIEF.md
# Loop Counter Branch Unit

This unit carries out the loop step of a counting loop in one operation. It decrements, increments or only tests one register, writes the result back, and then decides whether to take a short relative branch. A single control byte holds all of the instruction's choices: which operation, which branch sense, the sign of the displacement and which register. An 8-bit displacement byte completes the offset. The branch offset is 9 bits wide and signed, and it is added to the program counter value that follows the instruction.

The unit drives the read address of an external register file. In the cycle of the start strobe it takes the read data back combinationally, computes the new value, and on the next clock edge presents a registered write request together with the next program counter and a taken flag. Registers A, B and the condition-code register are 8 bits wide. For these three the arithmetic and the zero test use only the low byte. The other five registers use the full register width. The operation code 11 is invalid: it raises an error flag and causes no write, and the program counter stays where it is.

Top module: `lcb_unit`

## Requirements
- R1: Operation code 00 in control bits 7:6 writes back the selected register's value minus one. The subtraction wraps, so 0x0000 becomes 0xFFFF on a 16-bit register.
- R2: Operation code 01 writes back the selected register's value unchanged.
- R3: Operation code 10 writes back the selected register's value plus one. The addition wraps, so 0xFFFF becomes 0x0000.
- R4: Operation code 11 sets err in the result cycle. It gives no register write, taken=0 and next_pc equal to the pc_in that came with the start strobe.
- R5: If control bit 5 is 1, the branch is taken when the updated value is nonzero. If bit 5 is 0, the branch is taken when the updated value is zero.
- R6: A taken branch sets next_pc to pc_in plus the signed offset formed from control bit 4 (the sign) and the displacement byte. The sum wraps at the program counter width.
- R7: When the branch is not taken, next_pc equals pc_in.
- R8: Control bits 2:0 select the register, with indices 0=A, 1=B, 2=CCR, 3=temp, 4=D, 5=X, 6=Y, 7=SP. That index drives rf_raddr, and it is also the write index. The write happens for every valid operation, whether or not the branch is taken.
- R9: For indices 0 to 2, the operation and the zero test use only the low 8 bits. The write data has its upper bits at zero, and any upper bits present in the read value are ignored.
- R10: valid, and rf_we for a valid operation, pulse high for exactly one cycle, one clock after start. With no start there is no valid and no write.
- R11: After reset, valid, taken, err, rf_we and next_pc are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation this cycle |
| ctrl | input | 8 | Control byte: operation, branch sense, displacement sign, register index |
| disp | input | DISP_W | Low displacement bits |
| pc_in | input | PC_W | Program counter value following the instruction |
| rf_raddr | output | 3 | Register file read index |
| rf_rdata | input | REG_W | Register file read data, returned combinationally |
| rf_we | output | 1 | Register file write enable |
| rf_waddr | output | 3 | Register file write index |
| rf_wdata | output | REG_W | Register file write data |
| next_pc | output | PC_W | Next program counter |
| taken | output | 1 | Branch taken |
| err | output | 1 | Invalid operation code |
| valid | output | 1 | Result strobe |

## Verification
The bench builds the unit with its default parameters: 16-bit registers and program counter, an 8-bit narrow width and an 8-bit displacement byte. With these sizes a few hand-picked values reach both the 16-bit and the 8-bit wrap points, a target that wraps past the top of the address space, and the negative half of the 9-bit offset. A register model in the bench answers the read port and takes the writes, so every check on a write-back is made on what the register holds afterwards.

// File: rtl/lcb_pkg.sv
package lcb_pkg;
  localparam int SEL_W = 3;
  localparam logic [SEL_W-1:0] LAST_NARROW = 3'd2;

  typedef enum logic [1:0] {
    OP_DEC = 2'b00,
    OP_TST = 2'b01,
    OP_INC = 2'b10,
    OP_BAD = 2'b11
  } lcb_op_e;

  typedef struct packed {
    lcb_op_e          op;
    logic             on_nonzero;
    logic             disp_sign;
    logic [SEL_W-1:0] sel;
  } lcb_ctl_t;
endpackage

// File: rtl/lcb_decode.sv
module lcb_decode
  import lcb_pkg::*;
(
  input  logic [7:0] ctrl,
  output lcb_ctl_t   fields,
  output logic       narrow,
  output logic       bad
);
  always_comb begin
    fields.op         = lcb_op_e'(ctrl[7:6]);
    fields.on_nonzero = ctrl[5];
    fields.disp_sign  = ctrl[4];
    fields.sel        = ctrl[SEL_W-1:0];
  end

  assign narrow = (fields.sel <= LAST_NARROW);
  assign bad    = (fields.op == OP_BAD);
endmodule

// File: rtl/lcb_counter.sv
module lcb_counter
  import lcb_pkg::*;
#(
  parameter int REG_W    = 16,
  parameter int NARROW_W = 8
) (
  input  lcb_op_e          op,
  input  logic             narrow,
  input  logic [REG_W-1:0] cur,
  output logic [REG_W-1:0] nxt,
  output logic             is_zero
);
  logic [REG_W-1:0] step;
  logic [REG_W-1:0] wide_nxt;

  always_comb begin
    case (op)
      OP_DEC:  step = '1;
      OP_INC:  step = REG_W'(1);
      default: step = '0;
    endcase
  end

  assign wide_nxt = cur + step;

  generate
    if (NARROW_W < REG_W) begin : g_split
      logic [NARROW_W-1:0] low_nxt;
      assign low_nxt = cur[NARROW_W-1:0] + step[NARROW_W-1:0];
      assign nxt     = narrow ? {{(REG_W-NARROW_W){1'b0}}, low_nxt} : wide_nxt;
      assign is_zero = narrow ? (low_nxt == '0) : (wide_nxt == '0);
    end else begin : g_flat
      logic unused_narrow;
      assign unused_narrow = narrow;
      assign nxt     = wide_nxt;
      assign is_zero = (wide_nxt == '0);
    end
  endgenerate
endmodule

// File: rtl/lcb_target.sv
module lcb_target #(
  parameter int PC_W   = 16,
  parameter int DISP_W = 8
) (
  input  logic [PC_W-1:0]   pc,
  input  logic              sign,
  input  logic [DISP_W-1:0] disp,
  output logic [PC_W-1:0]   target
);
  localparam int OFF_W = DISP_W + 1;

  logic [PC_W-1:0] offs;

  generate
    if (PC_W > OFF_W) begin : g_extend
      assign offs = {{(PC_W-OFF_W){sign}}, sign, disp};
    end else begin : g_trunc
      logic [OFF_W-1:0] full;
      assign full = {sign, disp};
      assign offs = full[PC_W-1:0];
    end
  endgenerate

  assign target = pc + offs;
endmodule

// File: rtl/lcb_unit.sv
module lcb_unit
  import lcb_pkg::*;
#(
  parameter int PC_W     = 16,
  parameter int REG_W    = 16,
  parameter int NARROW_W = 8,
  parameter int DISP_W   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [7:0]        ctrl,
  input  logic [DISP_W-1:0] disp,
  input  logic [PC_W-1:0]   pc_in,
  output logic [SEL_W-1:0]  rf_raddr,
  input  logic [REG_W-1:0]  rf_rdata,
  output logic              rf_we,
  output logic [SEL_W-1:0]  rf_waddr,
  output logic [REG_W-1:0]  rf_wdata,
  output logic [PC_W-1:0]   next_pc,
  output logic              taken,
  output logic              err,
  output logic              valid
);
  lcb_ctl_t         fields;
  logic             narrow;
  logic             bad;
  logic [REG_W-1:0] upd;
  logic             upd_zero;
  logic [PC_W-1:0]  target;
  logic             go;

  lcb_decode u_dec (
    .ctrl   (ctrl),
    .fields (fields),
    .narrow (narrow),
    .bad    (bad)
  );

  lcb_counter #(.REG_W(REG_W), .NARROW_W(NARROW_W)) u_cnt (
    .op      (fields.op),
    .narrow  (narrow),
    .cur     (rf_rdata),
    .nxt     (upd),
    .is_zero (upd_zero)
  );

  lcb_target #(.PC_W(PC_W), .DISP_W(DISP_W)) u_tgt (
    .pc     (pc_in),
    .sign   (fields.disp_sign),
    .disp   (disp),
    .target (target)
  );

  assign rf_raddr = fields.sel;
  assign go       = !bad && (fields.on_nonzero ? !upd_zero : upd_zero);

  always_ff @(posedge clk) begin
    if (rst) begin
      valid    <= 1'b0;
      err      <= 1'b0;
      taken    <= 1'b0;
      rf_we    <= 1'b0;
      rf_waddr <= '0;
      rf_wdata <= '0;
      next_pc  <= '0;
    end else begin
      valid <= start;
      err   <= start && bad;
      taken <= start && go;
      rf_we <= start && !bad;
      if (start) begin
        rf_waddr <= fields.sel;
        rf_wdata <= upd;
        next_pc  <= go ? target : pc_in;
      end
    end
  end
endmodule

// File: rtl/lcb_unit_chk.sv
module lcb_unit_chk #(
  parameter int PC_W     = 16,
  parameter int REG_W    = 16,
  parameter int NARROW_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic [7:0]       ctrl,
  input logic [PC_W-1:0]  pc_in,
  input logic             rf_we,
  input logic [2:0]       rf_waddr,
  input logic [REG_W-1:0] rf_wdata,
  input logic [PC_W-1:0]  next_pc,
  input logic             taken,
  input logic             err,
  input logic             valid
);
  p_valid_after_start_r10: assert property (@(posedge clk) disable iff (rst)
    start |=> valid);

  p_quiet_when_idle_r10: assert property (@(posedge clk) disable iff (rst)
    !start |=> (!valid && !rf_we));

  p_bad_flag_r4: assert property (@(posedge clk) disable iff (rst)
    (start && ctrl[7:6] == 2'b11) |=> (err && !rf_we && !taken));

  p_bad_pc_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (valid && err) |-> (next_pc == $past(pc_in)));

  p_not_taken_pc_r7: assert property (@(posedge clk) disable iff (rst)
    (valid && !taken) |-> (next_pc == $past(pc_in)));

  p_write_index_r8: assert property (@(posedge clk) disable iff (rst)
    rf_we |-> (rf_waddr == $past(ctrl[2:0])));

  p_good_op_writes_r8: assert property (@(posedge clk) disable iff (rst)
    (valid && !err) |-> rf_we);

  p_narrow_upper_r9: assert property (@(posedge clk) disable iff (rst)
    (rf_we && rf_waddr <= 3'd2) |-> ((rf_wdata >> NARROW_W) == '0));

  p_branch_sense_r5: assert property (@(posedge clk) disable iff (rst)
    (valid && !err) |-> (taken == ($past(ctrl[5]) == (rf_wdata != '0))));
endmodule

bind lcb_unit lcb_unit_chk #(.PC_W(PC_W), .REG_W(REG_W), .NARROW_W(NARROW_W)) chk_i (.*);

// File: tb/lcb_unit_tb_top.sv
module lcb_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [7:0]  ctrl = '0;
  logic [7:0]  disp = '0;
  logic [15:0] pc_in = '0;
  logic [2:0]  rf_raddr;
  logic [15:0] rf_rdata;
  logic        rf_we;
  logic [2:0]  rf_waddr;
  logic [15:0] rf_wdata;
  logic [15:0] next_pc;
  logic        taken;
  logic        err;
  logic        valid;

  logic [15:0] regs [8];
  int n_checks = 0;
  int n_errs   = 0;

  always #5 clk = ~clk;

  lcb_unit dut_i (
    .clk(clk), .rst(rst), .start(start), .ctrl(ctrl), .disp(disp),
    .pc_in(pc_in), .rf_raddr(rf_raddr), .rf_rdata(rf_rdata),
    .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
    .next_pc(next_pc), .taken(taken), .err(err), .valid(valid)
  );

  assign rf_rdata = regs[rf_raddr];

  always @(posedge clk) begin
    if (rf_we) regs[rf_waddr] <= rf_wdata;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
    $finish;
  endtask

  // One operation: preload, strobe, check the result cycle, then the register.
  task automatic run_op(input string tag, input logic [7:0] c, input logic [7:0] d,
                        input logic [15:0] pc, input logic [15:0] init);
    logic [2:0]  idx;
    logic [1:0]  op;
    logic        nar;
    logic [15:0] val;
    logic [15:0] nv;
    logic        zero;
    logic        exp_tk;
    logic [15:0] off;
    logic [15:0] exp_pc;
    idx = c[2:0];
    op  = c[7:6];
    nar = (idx <= 3'd2);
    val = nar ? {8'h00, init[7:0]} : init;
    case (op)
      2'b00:   nv = val - 16'd1;
      2'b10:   nv = val + 16'd1;
      default: nv = val;
    endcase
    if (nar) nv = {8'h00, nv[7:0]};
    zero   = (nv == 16'h0000);
    exp_tk = (op != 2'b11) && (c[5] ? !zero : zero);
    off    = {{8{c[4]}}, d};
    exp_pc = exp_tk ? pc + off : pc;

    @(negedge clk);
    regs[idx] = init;
    ctrl  = c;
    disp  = d;
    pc_in = pc;
    start = 1'b1;
    #1;
    chk({tag, " R8 raddr"}, 32'(rf_raddr), 32'(idx));
    @(negedge clk);
    start = 1'b0;
    chk({tag, " R10 valid"}, 32'(valid), 32'd1);
    chk({tag, " R4 err"}, 32'(err), 32'(op == 2'b11));
    chk({tag, " R8 we"}, 32'(rf_we), 32'(op != 2'b11));
    chk({tag, " R5 taken"}, 32'(taken), 32'(exp_tk));
    chk({tag, " R6/R7 next_pc"}, 32'(next_pc), 32'(exp_pc));
    if (op != 2'b11) begin
      chk({tag, " R8 waddr"}, 32'(rf_waddr), 32'(idx));
      chk({tag, " R1/R2/R3/R9 wdata"}, 32'(rf_wdata), 32'(nv));
    end
    @(negedge clk);
    chk({tag, " R10 single pulse"}, 32'({valid, rf_we}), 32'd0);
    chk({tag, " R8 reg after"}, 32'(regs[idx]), 32'((op == 2'b11) ? init : nv));
  endtask

  task automatic t_reset();
    chk("R11 reset valid", 32'(valid), 32'd0);
    chk("R11 reset taken", 32'(taken), 32'd0);
    chk("R11 reset err", 32'(err), 32'd0);
    chk("R11 reset we", 32'(rf_we), 32'd0);
    chk("R11 reset next_pc", 32'(next_pc), 32'd0);
  endtask

  // R1 R9 R5: A holds 0x3401, low byte 1 -> 0, branch on zero
  task automatic t_dec_narrow();
    run_op("dec A", 8'h00, 8'h10, 16'h0200, 16'h3401);
  endtask

  // R1 R6: X 0x0000 -> 0xFFFF, nonzero sense, negative offset
  task automatic t_dec_wide_wrap();
    run_op("dec X", 8'h35, 8'hF0, 16'h1000, 16'h0000);
  endtask

  // R3 R9: B 0x12FF -> 0x0000, zero sense taken, positive offset
  task automatic t_inc_narrow();
    run_op("inc B", 8'h81, 8'h7F, 16'h0400, 16'h12FF);
  endtask

  // R3 R7: SP 0xFFFF -> 0x0000, nonzero sense so not taken, still written
  task automatic t_inc_wide_wrap();
    run_op("inc SP", 8'hA7, 8'h20, 16'h0500, 16'hFFFF);
  endtask

  // R2 R7: Y nonzero, zero sense -> not taken
  task automatic t_test_not_taken();
    run_op("tst Y", 8'h46, 8'h33, 16'h0600, 16'h0042);
  endtask

  // R2 R6: D nonzero, offset -256 wraps the target below zero
  task automatic t_test_taken_wrap();
    run_op("tst D", 8'h74, 8'h00, 16'h0010, 16'h8000);
  endtask

  // R9 R1: CCR low byte 0 with upper bits set -> 0x00FF
  task automatic t_dec_ccr();
    run_op("dec CCR", 8'h22, 8'h05, 16'hFFF0, 16'hAB00);
  endtask

  // R3: temp is a full-width register, carry into upper byte
  task automatic t_inc_temp();
    run_op("inc tmp", 8'hA3, 8'h40, 16'h0700, 16'h00FF);
  endtask

  // R4: invalid code, nothing written, pc held
  task automatic t_bad();
    run_op("bad op", 8'hF5, 8'h01, 16'h0800, 16'h0000);
  endtask

  // R10: no strobe, no result
  task automatic t_idle();
    regs[4] = 16'h5555;
    repeat (3) @(negedge clk);
    chk("R10 idle valid", 32'(valid), 32'd0);
    chk("R10 idle we", 32'(rf_we), 32'd0);
    chk("R10 idle reg", 32'(regs[4]), 32'h5555);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) regs[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst = 1'b0;
    t_dec_narrow();
    t_dec_wide_wrap();
    t_inc_narrow();
    t_inc_wide_wrap();
    t_test_not_taken();
    t_test_taken_wrap();
    t_dec_ccr();
    t_inc_temp();
    t_bad();
    t_idle();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_errs++;
    $display("FAIL watchdog R10 actual=timeout expected=done");
    finish_run();
  end
endmodule